// File: doc/BRIEF.md
# UART Receive Queue with Interrupt Causes

This block sits behind a serial deserializer on the receive side of a UART. Each incoming character arrives on a one-cycle strobe with its byte and three line-condition flags: break seen, parity wrong, framing wrong. The block stores the byte and its flags together as one entry in a 16-deep first-in first-out queue. Software reaches the block through a small register port with a read strobe and a write strobe. A read strobe on the data address removes the oldest entry.

Three interrupt causes are tracked:
- overrun, where a character was lost;
- fill level above a programmable threshold;
- data left waiting longer than a programmable number of character times.

Each cause has its own enable bit. The interrupt line is the OR of the enabled causes. The overrun cause is sticky and clears only through the queue-flush control bit. Character time is marked by a one-cycle tick from the deserializer, so the wait limit is counted in characters and not in clock cycles.

Top module: `uart_rx_queue`

## Requirements
- R1: The queue holds up to 16 entries and returns them in arrival order. A data-address read (address 3) returns the byte in bits [7:0], valid in bit 8, break in bit 9, parity error in bit 10 and frame error in bit 11, each flag as it arrived with that byte.
- R2: A read strobe at address 3 removes one entry only when the queue is non-empty. With the queue empty, such a read returns all zeros and changes no state.
- R3: Bit 11 of the interrupt register (address 2) is 1 exactly when the queue holds at least one entry.
- R4: A character that arrives while the queue holds 16 entries is dropped and sets the overrun raw status (bit 8 of address 2). The stored entries stay intact.
- R5: Once set, overrun raw status stays set through any number of data reads.
- R6: Writing 1 to bit 0 of the control register (address 0) empties the queue and clears overrun on the next clock edge. The bit then reads back 0 without any further write.
- R7: Threshold raw status (bit 9 of address 2) is 1 while the fill count is strictly greater than the threshold register (address 1, bits [4:0]). The threshold resets to 8.
- R8: Timeout raw status (bit 10 of address 2) rises once the queue has been non-empty for the number of character ticks in control bits [15:8] with no push or pop in between. Any push or pop restarts the count, and an empty queue holds it at zero. A limit of 0 disables the cause. The limit resets to 1.
- R9: Enable bits [2:0] of address 2 gate overrun, threshold and timeout respectively. The interrupt output is the OR of the enabled raw causes. All enables reset to 0.
- R10: After reset the interrupt register reads 0, the control register reads 0x0100, the threshold reads 8, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_valid_i | input | 1 | One-cycle strobe: a received character is present |
| char_data_i | input | 8 | Received byte |
| char_brk_i | input | 1 | Break condition seen on this character |
| char_par_i | input | 1 | Parity error on this character |
| char_frm_i | input | 1 | Frame error on this character |
| char_tick_i | input | 1 | One-cycle pulse per character time |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops at address 3) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the current address |
| irq_o | output | 1 | Interrupt request, OR of the enabled causes |

## Verification
The checks assume the following about the inputs:
- the character strobe and the character tick are single-cycle pulses;
- a register write and a register read never share a cycle;
- the flush bit is not written again in the cycle right after it was set.

The bench meets these conditions by driving every strobe from a task that raises it for exactly one cycle and then lowers it. The timeout checks depend on ticks arriving only while the bench is counting character times. No tick is issued while entries are being pushed or read.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int unsigned CHAR_W  = 8;
    localparam int unsigned REG_W   = 16;
    localparam int unsigned CAUSE_N = 3;

    // cause index doubles as enable and raw bit position
    localparam int unsigned CAUSE_OVR = 0;
    localparam int unsigned CAUSE_THR = 1;
    localparam int unsigned CAUSE_TMO = 2;

    typedef struct packed {
        logic              frm;
        logic              par;
        logic              brk;
        logic [CHAR_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_LEVEL = 2'd1,
        ADDR_IRQ   = 2'd2,
        ADDR_DATA  = 2'd3
    } rxq_addr_e;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_req_i,
    input  rxq_entry_t    entry_i,
    input  logic          pop_req_i,
    input  logic          flush_i,
    output rxq_entry_t    head_o,
    output logic [CW-1:0] count_o,
    output logic          ovr_o,
    output logic          push_ok_o,
    output logic          pop_ok_o
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } store_st_t;

    store_st_t st_d, st_q;
    rxq_entry_t mem_q [DEPTH];

    logic full, empty, drop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full      = (st_q.cnt == CW'(DEPTH));
        empty     = (st_q.cnt == '0);
        push_ok_o = push_req_i && !full && !flush_i;
        pop_ok_o  = pop_req_i && !empty && !flush_i;
        drop      = push_req_i && full && !flush_i;

        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (push_ok_o) st_d.wp = ptr_next(st_q.wp);
            if (pop_ok_o)  st_d.rp = ptr_next(st_q.rp);
            st_d.cnt = st_q.cnt + CW'(push_ok_o) - CW'(pop_ok_o);
            if (drop) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (push_ok_o) mem_q[st_q.wp] <= entry_i;
    end

    assign head_o  = mem_q[st_q.rp];
    assign count_o = st_q.cnt;
    assign ovr_o   = st_q.ovr;

    // R1: fill level never exceeds the depth
    p_count_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o <= CW'(DEPTH));

    // R2: a pop on an empty queue leaves it empty
    p_empty_pop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_req_i && count_o == '0 && !push_req_i) |=> (count_o == '0));

    // R4: arrival on a full queue is dropped and flagged
    p_drop_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_req_i && count_o == CW'(DEPTH) && !pop_req_i && !flush_i)
        |=> (count_o == CW'(DEPTH) && ovr_o));

    // R5: overrun persists until a flush
    p_ovr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovr_o && !flush_i) |=> ovr_o);

    // R6: flush empties the queue and clears overrun
    p_flush_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (count_o == '0 && !ovr_o));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic             nonempty_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
    } timer_st_t;

    timer_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!nonempty_i || restart_i || limit_i == '0) begin
            st_d.cnt = '0;
        end else if (tick_i && st_q.cnt < limit_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        expired_o = nonempty_i && (limit_i != '0) && (st_q.cnt >= limit_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R8: an empty queue forces the wait counter to zero
    p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !nonempty_i |=> (st_q.cnt == '0));

    // R8: without ticks or activity the wait count holds
    p_hold_no_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nonempty_i && !restart_i && !tick_i && limit_i != '0) |=> $stable(st_q.cnt));

endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned TMO_W = 8,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [1:0]         addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic               flush_o,
    output logic [TMO_W-1:0]   tmo_o,
    output logic [CW-1:0]      thresh_o,
    output logic [CAUSE_N-1:0] mask_o
);

    typedef struct packed {
        logic               flush;
        logic [TMO_W-1:0]   tmo;
        logic [CW-1:0]      thresh;
        logic [CAUSE_N-1:0] mask;
    } regs_st_t;

    localparam regs_st_t RST_VAL = '{
        flush:  1'b0,
        tmo:    TMO_W'(1),
        thresh: CW'(DEPTH / 2),
        mask:   '0
    };

    regs_st_t st_d, st_q;
    logic     unused_wdata;
    logic     ctrl_wr;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        ctrl_wr    = wr_i && (addr_i == ADDR_CTRL);
        if (wr_i) begin
            case (addr_i)
                ADDR_CTRL: begin
                    st_d.flush = wdata_i[0];
                    st_d.tmo   = wdata_i[8 +: TMO_W];
                end
                ADDR_LEVEL: st_d.thresh = wdata_i[CW-1:0];
                ADDR_IRQ:   st_d.mask   = wdata_i[CAUSE_N-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RST_VAL;
        else         st_q <= st_d;
    end

    assign flush_o  = st_q.flush;
    assign tmo_o    = st_q.tmo;
    assign thresh_o = st_q.thresh;
    assign mask_o   = st_q.mask;

    // R6: the flush bit drops by itself one cycle after it is set
    p_flush_selfclear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_o && !(ctrl_wr && wdata_i[0])) |=> !flush_o);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned TMO_W = 8,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              char_valid_i,
    input  logic [CHAR_W-1:0] char_data_i,
    input  logic              char_brk_i,
    input  logic              char_par_i,
    input  logic              char_frm_i,
    input  logic              char_tick_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);

    rxq_entry_t         in_entry, head;
    logic [CW-1:0]      count, thresh;
    logic [TMO_W-1:0]   tmo;
    logic [CAUSE_N-1:0] mask, raw;
    logic               ovr, flush, expired, nonempty;
    logic               push_ok, pop_ok, pop_req;

    assign in_entry = '{frm: char_frm_i, par: char_par_i, brk: char_brk_i, data: char_data_i};
    assign pop_req  = reg_rd_i && (reg_addr_i == ADDR_DATA);
    assign nonempty = (count != '0);

    rxq_regs #(.DEPTH(DEPTH), .TMO_W(TMO_W)) i_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .flush_o  (flush),
        .tmo_o    (tmo),
        .thresh_o (thresh),
        .mask_o   (mask)
    );

    rxq_store #(.DEPTH(DEPTH)) i_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_req_i (char_valid_i),
        .entry_i    (in_entry),
        .pop_req_i  (pop_req),
        .flush_i    (flush),
        .head_o     (head),
        .count_o    (count),
        .ovr_o      (ovr),
        .push_ok_o  (push_ok),
        .pop_ok_o   (pop_ok)
    );

    rxq_timer #(.TMO_W(TMO_W)) i_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (char_tick_i),
        .restart_i  (push_ok || pop_ok),
        .nonempty_i (nonempty),
        .limit_i    (tmo),
        .expired_o  (expired)
    );

    always_comb begin
        raw            = '0;
        raw[CAUSE_OVR] = ovr;
        raw[CAUSE_THR] = (count > thresh);
        raw[CAUSE_TMO] = expired;
        irq_o          = |(raw & mask);

        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_CTRL: begin
                reg_rdata_o[0]          = flush;
                reg_rdata_o[8 +: TMO_W] = tmo;
            end
            ADDR_LEVEL: reg_rdata_o[CW-1:0] = thresh;
            ADDR_IRQ: begin
                reg_rdata_o[CAUSE_N-1:0]   = mask;
                reg_rdata_o[8 +: CAUSE_N]  = raw;
                reg_rdata_o[11]            = nonempty;
            end
            default: begin
                if (nonempty) begin
                    reg_rdata_o[CHAR_W-1:0] = head.data;
                    reg_rdata_o[8]          = 1'b1;
                    reg_rdata_o[9]          = head.brk;
                    reg_rdata_o[10]         = head.par;
                    reg_rdata_o[11]         = head.frm;
                end
            end
        endcase
    end

    // R2: a data read from an empty queue never reports valid
    p_empty_read_invalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == ADDR_DATA && count == '0) |-> !reg_rdata_o[8]);

    // R9: no enabled cause means no interrupt
    p_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask == '0) |-> !irq_o);

endmodule

// File: tb/test_uart_rx_queue.sv
module test_uart_rx_queue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cv = 1'b0;
    logic [7:0]  cd = '0;
    logic        cb = 1'b0, cp = 1'b0, cf = 1'b0, tick = 1'b0;
    logic        rwr = 1'b0, rrd = 1'b0;
    logic [1:0]  raddr = '0;
    logic [15:0] rwdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] tmo_cur = 8'd1;

    always #10 clk = ~clk;

    uart_rx_queue i_uart_rx_queue (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .char_valid_i (cv),
        .char_data_i  (cd),
        .char_brk_i   (cb),
        .char_par_i   (cp),
        .char_frm_i   (cf),
        .char_tick_i  (tick),
        .reg_wr_i     (rwr),
        .reg_rd_i     (rrd),
        .reg_addr_i   (raddr),
        .reg_wdata_i  (rwdata),
        .reg_rdata_o  (rdata),
        .irq_o        (irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic b, input logic p, input logic f);
        @(negedge clk);
        cv = 1'b1; cd = d; cb = b; cp = p; cf = f;
        @(negedge clk);
        cv = 1'b0; cb = 1'b0; cp = 1'b0; cf = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        rwr = 1'b1; raddr = a; rwdata = v;
        @(negedge clk);
        rwr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        raddr = a; rrd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rrd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        raddr = a;
        #1 v = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_flush();
        wr(2'd0, {tmo_cur, 8'h01});
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(2'd2, v); chk("R10 irq reg", v, 16'h0000);
        peek(2'd0, v); chk("R10 ctrl reg", v, 16'h0100);
        peek(2'd1, v); chk("R10 threshold", v, 16'h0008);
        chk("R10 irq line", {15'd0, irq}, 16'd0);
        peek(2'd3, v); chk("R2 empty data at reset", v, 16'h0000);
    endtask

    task automatic t_order();
        logic [15:0] v;
        push(8'hA5, 1'b0, 1'b0, 1'b0);
        push(8'h3C, 1'b1, 1'b0, 1'b0);
        push(8'h7E, 1'b0, 1'b1, 1'b1);
        peek(2'd2, v); chk("R3 not-empty set", {15'd0, v[11]}, 16'd1);
        rd(2'd3, v); chk("R1 first entry", v, 16'h01A5);
        rd(2'd3, v); chk("R1 break flag entry", v, 16'h033C);
        rd(2'd3, v); chk("R1 parity+frame entry", v, 16'h0D7E);
        peek(2'd2, v); chk("R3 not-empty cleared", {15'd0, v[11]}, 16'd0);
        rd(2'd3, v); chk("R2 read when empty", v, 16'h0000);
        peek(2'd2, v); chk("R2 empty read no effect", {15'd0, v[11]}, 16'd0);
    endtask

    task automatic t_thresh();
        logic [15:0] v;
        for (int i = 0; i < 8; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
        peek(2'd2, v); chk("R7 level 8 not above 8", {15'd0, v[9]}, 16'd0);
        push(8'd8, 1'b0, 1'b0, 1'b0);
        peek(2'd2, v); chk("R7 level 9 above 8", {15'd0, v[9]}, 16'd1);
        wr(2'd1, 16'd9);
        peek(2'd2, v); chk("R7 level 9 not above 9", {15'd0, v[9]}, 16'd0);
        wr(2'd1, 16'd2);
        peek(2'd2, v); chk("R7 level 9 above 2", {15'd0, v[9]}, 16'd1);
        rd(2'd3, v); chk("R1 oldest after fill", v, 16'h0100);
        for (int i = 1; i < 7; i++) rd(2'd3, v);
        chk("R1 seventh entry", v, 16'h0106);
        peek(2'd2, v); chk("R7 level 2 not above 2", {15'd0, v[9]}, 16'd0);
        do_flush();
        wr(2'd1, 16'd8);
    endtask

    task automatic t_overrun();
        logic [15:0] v;
        for (int i = 0; i < 16; i++) push(8'h40 + 8'(i), 1'b0, 1'b0, 1'b0);
        peek(2'd2, v); chk("R4 full without overrun", {15'd0, v[8]}, 16'd0);
        push(8'hEE, 1'b1, 1'b1, 1'b1);
        peek(2'd2, v); chk("R4 overrun raised", {15'd0, v[8]}, 16'd1);
        for (int i = 0; i < 16; i++) begin
            rd(2'd3, v);
            chk("R4 stored entry intact", v, 16'h0140 + 16'(i));
        end
        rd(2'd3, v); chk("R4 dropped char absent", v, 16'h0000);
        peek(2'd2, v); chk("R5 overrun kept after reads", {15'd0, v[8]}, 16'd1);
        do_flush();
        peek(2'd2, v); chk("R6 overrun cleared by flush", {15'd0, v[8]}, 16'd0);
        peek(2'd0, v); chk("R6 flush bit self-clears", {15'd0, v[0]}, 16'd0);
        push(8'h11, 1'b0, 1'b0, 1'b0);
        push(8'h22, 1'b0, 1'b0, 1'b0);
        do_flush();
        peek(2'd2, v); chk("R6 flush empties queue", {15'd0, v[11]}, 16'd0);
        rd(2'd3, v); chk("R6 nothing left after flush", v, 16'h0000);
    endtask

    task automatic t_timeout();
        logic [15:0] v;
        tmo_cur = 8'd3;
        wr(2'd0, 16'h0300);
        peek(2'd0, v); chk("R8 limit readback", v, 16'h0300);
        push(8'h55, 1'b0, 1'b0, 1'b0);
        ticks(2);
        peek(2'd2, v); chk("R8 two ticks short of three", {15'd0, v[10]}, 16'd0);
        ticks(1);
        peek(2'd2, v); chk("R8 three ticks expire", {15'd0, v[10]}, 16'd1);
        push(8'h56, 1'b0, 1'b0, 1'b0);
        peek(2'd2, v); chk("R8 push restarts wait", {15'd0, v[10]}, 16'd0);
        ticks(3);
        peek(2'd2, v); chk("R8 expire after push", {15'd0, v[10]}, 16'd1);
        rd(2'd3, v);
        peek(2'd2, v); chk("R8 pop restarts wait", {15'd0, v[10]}, 16'd0);
        ticks(3);
        peek(2'd2, v); chk("R8 expire after pop", {15'd0, v[10]}, 16'd1);
        tmo_cur = 8'd0;
        wr(2'd0, 16'h0000);
        ticks(4);
        peek(2'd2, v); chk("R8 limit zero disables", {15'd0, v[10]}, 16'd0);
        do_flush();
        ticks(3);
        peek(2'd2, v); chk("R8 empty never times out", {15'd0, v[10]}, 16'd0);
        tmo_cur = 8'd1;
        wr(2'd0, 16'h0100);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        wr(2'd2, 16'h0002);
        peek(2'd2, v); chk("R9 enable readback", v & 16'h0007, 16'h0002);
        for (int i = 0; i < 9; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
        chk("R9 threshold enabled drives irq", {15'd0, irq}, 16'd1);
        wr(2'd2, 16'h0000);
        chk("R9 all disabled quiet", {15'd0, irq}, 16'd0);
        wr(2'd2, 16'h0004);
        chk("R9 timeout enabled not yet expired", {15'd0, irq}, 16'd0);
        ticks(1);
        chk("R9 timeout enabled after one tick", {15'd0, irq}, 16'd1);
        do_flush();
        wr(2'd2, 16'h0001);
        chk("R9 overrun enabled none pending", {15'd0, irq}, 16'd0);
        for (int i = 0; i < 17; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
        chk("R9 overrun drives irq", {15'd0, irq}, 16'd1);
        do_flush();
        chk("R9 irq drops after flush", {15'd0, irq}, 16'd0);
        wr(2'd2, 16'h0000);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_thresh();
        t_overrun();
        t_timeout();
        t_mask();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule